// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block provides interrupt signalling between the two ports of a shared memory. The two highest word addresses serve as mailboxes. The second-highest word (all ones except bit 0) is port A's incoming mailbox, and the highest word (all ones) is port B's incoming mailbox. When one port writes the other port's incoming mailbox, the other port's active-low interrupt is raised. The receiving port lowers its own interrupt by accessing its incoming mailbox with select and output enable both asserted.

The block holds the two 16-bit mailbox words itself. It stores them, and returns them on reads, exactly as the surrounding array would. A feature enable controls the interrupt behaviour. With the enable low, both words are plain storage and no access touches the flags.

Everything is synchronous to a single clock. Flags and stored words change on the clock edge that ends the access cycle. Read data is presented combinationally during that cycle.

Top module: `mbx_dual_irq`

## Requirements
- R1: While rst_n is low at a clock edge, both interrupt outputs go high (inactive) and both mailbox words are cleared to zero.
- R2: With mbx_en high, a port B write (b_sel_n low, b_wr_n low) to address 0xFFFE drives a_irq_n low from the next clock edge.
- R3: With mbx_en high, a port A access to 0xFFFE with a_sel_n and a_oe_n both low returns a_irq_n high at the next edge, whatever the level of a_wr_n.
- R4: With mbx_en high, a port A write to 0xFFFF drives b_irq_n low from the next clock edge.
- R5: With mbx_en high, a port B access to 0xFFFF with b_sel_n and b_oe_n both low returns b_irq_n high at the next edge, whatever the level of b_wr_n.
- R6: When a set event and a clear event for the same flag fall in one cycle, the flag is low (set) after that edge.
- R7: A port writing its own incoming mailbox with its output enable high, and any access to an address other than the two mailbox words, leaves both interrupt outputs unchanged.
- R8: A write (sel_n low, wr_n low) to a mailbox word stores wdata at the edge. While sel_n and oe_n are low and the address is a mailbox word, rdata shows the stored word, which is the value before any write in that same cycle. Otherwise rdata is zero. The mbx_hit output is high when sel_n is low and the address is one of the two mailbox words.
- R9: When both ports write the same mailbox word in one cycle, the word takes port A's data.
- R10: With mbx_en low, no access changes either interrupt output, while storage and read-back per R8 and R9 still operate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mbx_en | input | 1 | High enables mailbox interrupts |
| a_sel_n | input | 1 | Port A select, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_wr_n | input | 1 | Port A write strobe, active low |
| a_addr | input | 16 | Port A word address |
| a_wdata | input | 16 | Port A write data |
| a_rdata | output | 16 | Port A mailbox read data |
| a_mbx_hit | output | 1 | Port A addresses a mailbox word |
| a_irq_n | output | 1 | Interrupt to port A, active low |
| b_sel_n | input | 1 | Port B select, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_wr_n | input | 1 | Port B write strobe, active low |
| b_addr | input | 16 | Port B word address |
| b_wdata | input | 16 | Port B write data |
| b_rdata | output | 16 | Port B mailbox read data |
| b_mbx_hit | output | 1 | Port B addresses a mailbox word |
| b_irq_n | output | 1 | Interrupt to port B, active low |

## Verification
Two events can land on the same flag in one cycle: a sender posting a new message and the receiver clearing the previous one. Directed cycles provoke this by having port B write 0xFFFE while port A reads 0xFFFE, and the mirror case on 0xFFFF. The flag is judged to be low after the edge. Random cycles bias both addresses toward the mailbox words, so the collision also recurs with random data and enable levels. Each outcome is compared against a bench model that lets set win over clear.

// File: rtl/mbx_pkg.sv
// Package: shared types for the mailbox interrupt block.
// Assumes one decode record per port, produced once per cycle.
package mbx_pkg;

    // Decoded view of one port's access in the current cycle
    typedef struct packed {
        logic hit_lo;   // address is the lower mailbox word
        logic hit_hi;   // address is the upper mailbox word
        logic wr;       // port selected and writing
        logic rd;       // port selected with output enable low
    } mbx_dec_t;

endpackage

// File: rtl/mbx_port_dec.sv
// Module: mbx_port_dec
// Decodes one port's control and address lines into mailbox hit and
// access strobes. Assumes mailbox words are the two highest addresses.
module mbx_port_dec
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              sel_n,
    input  logic              oe_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    output mbx_dec_t          dec
);
    localparam logic [ADDR_W-1:0] WORD_HI = '1;
    localparam logic [ADDR_W-1:0] WORD_LO = {{(ADDR_W-1){1'b1}}, 1'b0};

    // Compare the address against both mailbox words and form strobes
    always_comb begin
        dec.hit_lo = (addr == WORD_LO);
        dec.hit_hi = (addr == WORD_HI);
        dec.wr     = !sel_n && !wr_n;
        dec.rd     = !sel_n && !oe_n;
    end
endmodule

// File: rtl/mbx_word_store.sv
// Module: mbx_word_store
// Holds the mailbox words. Port A wins when both ports write one word
// in the same cycle. Assumes synchronous active-low reset to zero.
module mbx_word_store #(
    parameter int DATA_W = 16,
    parameter int WORDS  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [WORDS-1:0]              we_a,
    input  logic [WORDS-1:0]              we_b,
    input  logic [DATA_W-1:0]             wdata_a,
    input  logic [DATA_W-1:0]             wdata_b,
    output logic [WORDS-1:0][DATA_W-1:0]  words
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        // Capture one word, with port A taking priority on a tie
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[w] <= '0;
            end else if (we_a[w]) begin
                words[w] <= wdata_a;
            end else if (we_b[w]) begin
                words[w] <= wdata_b;
            end
        end
    end
endmodule

// File: rtl/mbx_irq_flag.sv
// Module: mbx_irq_flag
// One active-low interrupt flag. A set drives it low, a clear drives it
// high, and set wins when both occur. Assumes synchronous active-low reset.
module mbx_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n
);
    // Update the flag from this cycle's events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_n <= 1'b1;
        end else if (set_i) begin
            irq_n <= 1'b0;
        end else if (clr_i) begin
            irq_n <= 1'b1;
        end
    end
endmodule

// File: rtl/mbx_dual_irq.sv
// Module: mbx_dual_irq (top)
// Mailbox interrupt logic for a two-port shared memory. The lower
// mailbox word is port A's inbox and the upper word is port B's inbox.
// Assumes the surrounding array handles all other addresses and any
// collision arbitration.
module mbx_dual_irq
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mbx_en,
    input  logic              a_sel_n,
    input  logic              a_oe_n,
    input  logic              a_wr_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_mbx_hit,
    output logic              a_irq_n,
    input  logic              b_sel_n,
    input  logic              b_oe_n,
    input  logic              b_wr_n,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_mbx_hit,
    output logic              b_irq_n
);
    localparam int WORDS = 2;
    localparam int IDX_LO = 0;
    localparam int IDX_HI = 1;

    mbx_dec_t                        dec_a, dec_b;
    logic [WORDS-1:0]                we_a, we_b;
    logic [WORDS-1:0][DATA_W-1:0]    words;
    logic                            set_a, clr_a, set_b, clr_b;

    mbx_port_dec #(.ADDR_W(ADDR_W)) u_dec_a (
        .sel_n(a_sel_n), .oe_n(a_oe_n), .wr_n(a_wr_n), .addr(a_addr), .dec(dec_a)
    );
    mbx_port_dec #(.ADDR_W(ADDR_W)) u_dec_b (
        .sel_n(b_sel_n), .oe_n(b_oe_n), .wr_n(b_wr_n), .addr(b_addr), .dec(dec_b)
    );

    // Route each port's write strobe to the addressed mailbox word
    always_comb begin
        we_a[IDX_LO] = dec_a.wr && dec_a.hit_lo;
        we_a[IDX_HI] = dec_a.wr && dec_a.hit_hi;
        we_b[IDX_LO] = dec_b.wr && dec_b.hit_lo;
        we_b[IDX_HI] = dec_b.wr && dec_b.hit_hi;
    end

    mbx_word_store #(.DATA_W(DATA_W), .WORDS(WORDS)) u_store (
        .clk(clk), .rst_n(rst_n), .we_a(we_a), .we_b(we_b),
        .wdata_a(a_wdata), .wdata_b(b_wdata), .words(words)
    );

    // Form the interrupt events, all gated by the feature enable
    always_comb begin
        set_a = mbx_en && we_b[IDX_LO];
        clr_a = mbx_en && dec_a.rd && dec_a.hit_lo;
        set_b = mbx_en && we_a[IDX_HI];
        clr_b = mbx_en && dec_b.rd && dec_b.hit_hi;
    end

    mbx_irq_flag u_flag_a (
        .clk(clk), .rst_n(rst_n), .set_i(set_a), .clr_i(clr_a), .irq_n(a_irq_n)
    );
    mbx_irq_flag u_flag_b (
        .clk(clk), .rst_n(rst_n), .set_i(set_b), .clr_i(clr_b), .irq_n(b_irq_n)
    );

    // Present the addressed mailbox word on each port during a read
    always_comb begin
        a_mbx_hit = !a_sel_n && (dec_a.hit_lo || dec_a.hit_hi);
        b_mbx_hit = !b_sel_n && (dec_b.hit_lo || dec_b.hit_hi);
        a_rdata   = '0;
        b_rdata   = '0;
        if (dec_a.rd && dec_a.hit_lo) a_rdata = words[IDX_LO];
        if (dec_a.rd && dec_a.hit_hi) a_rdata = words[IDX_HI];
        if (dec_b.rd && dec_b.hit_lo) b_rdata = words[IDX_LO];
        if (dec_b.rd && dec_b.hit_hi) b_rdata = words[IDX_HI];
    end
endmodule

// File: rtl/mbx_dual_irq_chk.sv
// Module: mbx_dual_irq_chk
// Protocol checker for mbx_dual_irq, attached through bind. It observes
// the top-level ports only.
module mbx_dual_irq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mbx_en,
    input logic              a_sel_n,
    input logic              a_oe_n,
    input logic              a_wr_n,
    input logic [ADDR_W-1:0] a_addr,
    input logic              a_irq_n,
    input logic              b_sel_n,
    input logic              b_oe_n,
    input logic              b_wr_n,
    input logic [ADDR_W-1:0] b_addr,
    input logic              b_irq_n
);
    localparam logic [ADDR_W-1:0] TOP_WORD  = '1;
    localparam logic [ADDR_W-1:0] NEXT_WORD = {{(ADDR_W-1){1'b1}}, 1'b0};

    // R1: reset leaves both interrupts inactive
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (a_irq_n && b_irq_n));

    // R2: port B posting to 0xFFFE raises port A's interrupt
    assert_set_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mbx_en && !b_sel_n && !b_wr_n && b_addr == NEXT_WORD) |=> !a_irq_n);

    // R3: port A reading its inbox with no competing post lowers its interrupt
    assert_clear_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mbx_en && !a_sel_n && !a_oe_n && a_addr == NEXT_WORD
         && !(!b_sel_n && !b_wr_n && b_addr == NEXT_WORD)) |=> a_irq_n);

    // R4: port A posting to 0xFFFF raises port B's interrupt
    assert_set_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mbx_en && !a_sel_n && !a_wr_n && a_addr == TOP_WORD) |=> !b_irq_n);

    // R5: port B reading its inbox with no competing post lowers its interrupt
    assert_clear_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mbx_en && !b_sel_n && !b_oe_n && b_addr == TOP_WORD
         && !(!a_sel_n && !a_wr_n && a_addr == TOP_WORD)) |=> b_irq_n);

    // R10: with the feature off, neither interrupt moves
    assert_disabled_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mbx_en |=> ($stable(a_irq_n) && $stable(b_irq_n)));
endmodule

bind mbx_dual_irq mbx_dual_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mbx_en(mbx_en),
    .a_sel_n(a_sel_n), .a_oe_n(a_oe_n), .a_wr_n(a_wr_n), .a_addr(a_addr),
    .a_irq_n(a_irq_n),
    .b_sel_n(b_sel_n), .b_oe_n(b_oe_n), .b_wr_n(b_wr_n), .b_addr(b_addr),
    .b_irq_n(b_irq_n)
);

// File: tb/mbx_dual_irq_tb.sv
// Testbench for mbx_dual_irq: directed corner cases followed by seeded
// random cycles, all compared against a bench-side reference model.
module mbx_dual_irq_tb_top;
    localparam int    CLK_PERIOD = 10;
    localparam int    AW = 16;
    localparam int    DW = 16;
    localparam logic [AW-1:0] A_IN = 16'hFFFE;
    localparam logic [AW-1:0] B_IN = 16'hFFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mbx_en = 1'b1;
    logic a_sel_n = 1'b1, a_oe_n = 1'b1, a_wr_n = 1'b1;
    logic b_sel_n = 1'b1, b_oe_n = 1'b1, b_wr_n = 1'b1;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic [DW-1:0] a_rdata, b_rdata;
    logic a_mbx_hit, b_mbx_hit, a_irq_n, b_irq_n;

    int checks = 0;
    int fails  = 0;

    logic          m_a_irq = 1'b1, m_b_irq = 1'b1;
    logic [DW-1:0] m_lo = '0, m_hi = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_dual_irq #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .mbx_en(mbx_en),
        .a_sel_n(a_sel_n), .a_oe_n(a_oe_n), .a_wr_n(a_wr_n), .a_addr(a_addr),
        .a_wdata(a_wdata), .a_rdata(a_rdata), .a_mbx_hit(a_mbx_hit), .a_irq_n(a_irq_n),
        .b_sel_n(b_sel_n), .b_oe_n(b_oe_n), .b_wr_n(b_wr_n), .b_addr(b_addr),
        .b_wdata(b_wdata), .b_rdata(b_rdata), .b_mbx_hit(b_mbx_hit), .b_irq_n(b_irq_n)
    );

    // Expected read data for one port from the model state
    function automatic logic [DW-1:0] exp_rd(logic s, logic o, logic [AW-1:0] ad);
        if (!s && !o && ad == A_IN) return m_lo;
        if (!s && !o && ad == B_IN) return m_hi;
        return '0;
    endfunction

    // Next active-low flag value, set winning over clear
    function automatic logic exp_flag(logic cur, logic set, logic clr);
        if (set) return 1'b0;
        if (clr) return 1'b1;
        return cur;
    endfunction

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One access cycle: drive at negedge, check read path, clock, check flags
    task automatic cyc(logic en,
                       logic as, logic ao, logic aw, logic [AW-1:0] aa, logic [DW-1:0] ad,
                       logic bs, logic bo, logic bw, logic [AW-1:0] ba, logic [DW-1:0] bd,
                       string tag);
        logic sa, ca, sb, cb;
        mbx_en = en;
        a_sel_n = as; a_oe_n = ao; a_wr_n = aw; a_addr = aa; a_wdata = ad;
        b_sel_n = bs; b_oe_n = bo; b_wr_n = bw; b_addr = ba; b_wdata = bd;
        #1;
        check({tag, " R8 a_rdata"}, a_rdata, exp_rd(as, ao, aa));
        check({tag, " R8 b_rdata"}, b_rdata, exp_rd(bs, bo, ba));
        check({tag, " R8 a_hit"}, DW'(a_mbx_hit), DW'(!as && (aa == A_IN || aa == B_IN)));
        check({tag, " R8 b_hit"}, DW'(b_mbx_hit), DW'(!bs && (ba == A_IN || ba == B_IN)));
        sa = en && !bs && !bw && ba == A_IN;
        ca = en && !as && !ao && aa == A_IN;
        sb = en && !as && !aw && aa == B_IN;
        cb = en && !bs && !bo && ba == B_IN;
        m_a_irq = exp_flag(m_a_irq, sa, ca);
        m_b_irq = exp_flag(m_b_irq, sb, cb);
        if (!as && !aw && aa == A_IN) m_lo = ad;
        else if (!bs && !bw && ba == A_IN) m_lo = bd;
        if (!as && !aw && aa == B_IN) m_hi = ad;
        else if (!bs && !bw && ba == B_IN) m_hi = bd;
        @(posedge clk);
        @(negedge clk);
        check({tag, " a_irq_n"}, DW'(a_irq_n), DW'(m_a_irq));
        check({tag, " b_irq_n"}, DW'(b_irq_n), DW'(m_b_irq));
    endtask

    task automatic idle(logic en, string tag);
        cyc(en, 1, 1, 1, '0, '0, 1, 1, 1, '0, '0, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #(CLK_PERIOD * 150000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h00C0FFEE);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 a_irq_n after reset", DW'(a_irq_n), DW'(1'b1));
        check("R1 b_irq_n after reset", DW'(b_irq_n), DW'(1'b1));
        idle(1, "R1 idle");
        cyc(1, 0, 0, 1, A_IN, '0, 0, 0, 1, B_IN, '0, "R1 words zero");

        // R2 then R8 read-back then R3 clear
        cyc(1, 1, 1, 1, '0, '0, 0, 1, 0, A_IN, 16'h1234, "R2 B posts to A");
        cyc(1, 0, 0, 1, A_IN, '0, 1, 1, 1, '0, '0, "R3 A reads inbox R8");
        // R4 then R5 clear with write strobe low (R5 regardless of wr_n)
        cyc(1, 0, 1, 0, B_IN, 16'hBEEF, 1, 1, 1, '0, '0, "R4 A posts to B");
        cyc(1, 1, 1, 1, '0, '0, 0, 0, 0, B_IN, 16'h5A5A, "R5 B clears with wr low");
        // R3 regardless of wr_n
        cyc(1, 1, 1, 1, '0, '0, 0, 1, 0, A_IN, 16'h0F0F, "R2 second post");
        cyc(1, 0, 0, 0, A_IN, 16'h7777, 1, 1, 1, '0, '0, "R3 A clears with wr low");
        // Back-to-back messages
        cyc(1, 0, 1, 0, B_IN, 16'h0001, 1, 1, 1, '0, '0, "R4 msg1");
        cyc(1, 0, 1, 0, B_IN, 16'h0002, 1, 1, 1, '0, '0, "R4 msg2");
        cyc(1, 1, 1, 1, '0, '0, 0, 0, 1, B_IN, '0, "R5 read msg2 R8");
        // R6: set and clear in the same cycle, both flags
        cyc(1, 0, 0, 1, A_IN, '0, 0, 1, 0, A_IN, 16'hAAAA, "R6 A flag collide");
        cyc(1, 0, 1, 0, B_IN, 16'hBBBB, 0, 0, 1, B_IN, '0, "R6 B flag collide");
        // R7: own-inbox writes with oe high, and other addresses
        cyc(1, 0, 1, 0, A_IN, 16'hC001, 0, 1, 0, B_IN, 16'hC002, "R7 own inbox writes");
        cyc(1, 0, 0, 0, 16'h1234, 16'h1, 0, 0, 0, 16'hFFFD, 16'h2, "R7 other addrs");
        // R9: both write the same word
        cyc(1, 0, 1, 0, A_IN, 16'h1111, 0, 1, 0, A_IN, 16'h2222, "R9 tie lo");
        cyc(1, 0, 0, 1, A_IN, '0, 0, 0, 1, A_IN, '0, "R9 read lo");
        // R10: feature disabled
        cyc(0, 0, 1, 0, B_IN, 16'hD00D, 0, 1, 0, A_IN, 16'hFEED, "R10 posts ignored");
        cyc(0, 0, 0, 1, A_IN, '0, 0, 0, 1, B_IN, '0, "R10 reads ignored R8");
        cyc(1, 0, 0, 1, A_IN, '0, 0, 0, 1, B_IN, '0, "R3 R5 clear after enable");
        cyc(0, 1, 1, 1, '0, '0, 0, 1, 0, A_IN, 16'h3333, "R10 no set");

        // Random phase biased toward the mailbox words
        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] ra, rb;
            logic [31:0]   r;
            r  = $urandom;
            ra = (r[1:0] == 2'd0) ? AW'($urandom) : (r[2] ? A_IN : B_IN);
            rb = (r[4:3] == 2'd0) ? AW'($urandom) : (r[5] ? A_IN : B_IN);
            cyc(r[9:6] != 4'd0,
                r[10] & r[11], r[12], r[13], ra, DW'($urandom),
                r[14] & r[15], r[16], r[17], rb, DW'($urandom),
                "random R2 R3 R4 R5 R6 R7 R9 R10");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule